// File: doc/BRIEF.md
# Ancillary Packet Extractor and Remover

This block sits in a 10-bit parallel component video word path. It hunts for the three-word ancillary start marker and parses the header that follows it. The data ID of each packet is compared with three IDs that the host sets up: an audio ID, an extended-audio ID and a free-form ID. If any of them matches, the packet is selected. The secondary ID, the data count and every user word of a selected packet are then presented as 9-bit values on a side port, with a strobe. The checksum word of each selected packet is compared with a sum the block computes itself. A mismatch raises a sticky flag.

The video leaves the block through a fixed-length delay line. When the remove control is high as a selected packet's data ID arrives, every word of that packet is replaced in the outgoing video by blanking words. This covers the start marker through the checksum. Other packets pass through bit-exact, and so does all other video. Error-detection checkwords further down the stream are not recomputed. The delay line is long enough that the decision to delete is made before the first marker word reaches the output.

The parser has six named states:
- HUNT waits for the marker.
- DID reads the data ID and decides whether the packet is selected.
- SDID exports the secondary ID.
- DC exports the data count and loads a counter.
- UDW exports user words until the counter runs out.
- CS checks the checksum.

It moves through them in this order: HUNT→DID when the marker completes, DID→SDID, SDID→DC, DC→CS when the count is zero, otherwise DC→UDW, UDW→UDW while more than one user word remains, UDW→CS on the last user word, and CS→HUNT.

Top module: `anc_pkt_extractor`

## Requirements
- R1: While reset is held and after reset is released, `vid_out`, `pkt_valid` and `csum_err` are 0 until data reaches them.
- R2: A packet starts only after the consecutive input words 000h, 3FFh, 3FFh; the next word is the data ID. A broken marker (000h, 3FFh followed by any other word) starts no packet.
- R3: A packet is selected when bits [7:0] of its data ID equal `id_audio`, `id_ext_audio` or `id_arbitrary`.
- R4: For a selected packet, the secondary ID, the data count and each user word appear as bits [8:0] on `pkt_data`, with `pkt_valid` high, one cycle after that word is presented. `pkt_valid` is low for every other word, including the data ID and the checksum.
- R5: Bits [7:0] of the data count give the number of user words. A count of 0 makes the word after the data count the checksum.
- R6: If `remove_en` is high while a selected packet's data ID is on the input, every word of that packet from the first marker word through the checksum is blanked on `vid_out`.
- R7: The first word after reset has index 0. A blanked word at an even input index becomes 200h and one at an odd index becomes 040h.
- R8: Words outside removed packets pass to `vid_out` unchanged. This includes unselected packets, and selected packets seen while `remove_en` is low.
- R9: A word presented in cycle n appears on `vid_out` in cycle n+LAT (default LAT = 4).
- R10: For a selected packet, the 9-bit sum of bits [8:0] of the data ID through the last user word is compared with bits [8:0] of the checksum word. A mismatch sets `csum_err` one cycle after the checksum word is presented.
- R11: `csum_err` stays high until a cycle with `err_clr` high. If a new mismatch arrives in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_in | input | 10 | Incoming video word |
| remove_en | input | 1 | Delete selected packets from the video |
| id_audio | input | 8 | Audio packet data ID |
| id_ext_audio | input | 8 | Extended-audio packet data ID |
| id_arbitrary | input | 8 | Free-form packet data ID |
| err_clr | input | 1 | Clears the sticky checksum flag |
| vid_out | output | 10 | Delayed video, with removed packets blanked |
| pkt_data | output | 9 | Exported packet word |
| pkt_valid | output | 1 | High while `pkt_data` carries an exported word |
| csum_err | output | 1 | Sticky checksum mismatch flag |

## Verification
Each test drives a stream of words through the block.

- **Audio-ID packet with removal on.** This shows export and blanking together, including the alternating blank values.
- **Extended-ID packet with removal off.** Export continues while the video is left untouched.
- **Unlisted ID with removal on.** This separates matching from removal: nothing is exported and nothing is deleted.
- **Free-form-ID packet with a zero count.** The checksum must be found directly after the count.
- **Broken marker followed by a valid marker with a leading extra zero.** This checks that only the exact three-word sequence starts a packet.
- **Corrupted checksums with clear pulses placed before, on and after the bad word.** These cover the set, hold and clear timing of the error flag.

// File: rtl/anc_pkg.sv
package anc_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_DID,
        S_SDID,
        S_DC,
        S_UDW,
        S_CS
    } parse_st_t;

    localparam logic [9:0] MARK_LO = 10'h000;
    localparam logic [9:0] MARK_HI = 10'h3FF;

endpackage

// File: rtl/anc_parse_fsm.sv
module anc_parse_fsm
    import anc_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              remove_en,
    input  logic [ID_W-1:0]   id_a,
    input  logic [ID_W-1:0]   id_b,
    input  logic [ID_W-1:0]   id_c,
    input  logic              err_clr,
    output logic [WORD_W-2:0] pkt_data,
    output logic              pkt_valid,
    output logic              csum_err,
    output logic              kill_cur,
    output logic              retro
);
    localparam int PAY_W = WORD_W - 1;
    localparam int CNT_W = WORD_W - 2;

    parse_st_t         st, st_nx;
    logic [WORD_W-1:0] hist1, hist0;
    logic [PAY_W-1:0]  sum_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sel_q, sel_rm_q;
    logic              hit, flag_done, body;

    assign flag_done = (hist1 == MARK_LO) && (hist0 == MARK_HI) && (word == MARK_HI);
    assign hit = (word[ID_W-1:0] == id_a) || (word[ID_W-1:0] == id_b) ||
                 (word[ID_W-1:0] == id_c);
    assign body = (st == S_SDID) || (st == S_DC) || (st == S_UDW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_HUNT;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_HUNT: if (flag_done) st_nx = S_DID;
            S_DID:  st_nx = S_SDID;
            S_SDID: st_nx = S_DC;
            S_DC:   st_nx = (word[CNT_W-1:0] == '0) ? S_CS : S_UDW;
            S_UDW:  if (cnt_q == CNT_W'(1)) st_nx = S_CS;
            S_CS:   st_nx = S_HUNT;
            default: st_nx = S_HUNT;
        endcase
    end

    // outputs towards the delay line
    always_comb begin
        retro    = 1'b0;
        kill_cur = 1'b0;
        unique case (st)
            S_HUNT: kill_cur = 1'b0;
            S_DID: begin
                retro    = hit && remove_en;
                kill_cur = hit && remove_en;
            end
            S_SDID, S_DC, S_UDW, S_CS: kill_cur = sel_rm_q;
            default: kill_cur = 1'b0;
        endcase
    end

    // header datapath, export and checksum flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1     <= '0;
            hist0     <= '0;
            sum_q     <= '0;
            cnt_q     <= '0;
            sel_q     <= 1'b0;
            sel_rm_q  <= 1'b0;
            pkt_data  <= '0;
            pkt_valid <= 1'b0;
            csum_err  <= 1'b0;
        end else begin
            hist1     <= hist0;
            hist0     <= word;
            pkt_valid <= sel_q && body;
            pkt_data  <= word[PAY_W-1:0];
            if (st == S_DID) begin
                sel_q    <= hit;
                sel_rm_q <= hit && remove_en;
                sum_q    <= word[PAY_W-1:0];
            end
            if (body) sum_q <= sum_q + word[PAY_W-1:0];
            if (st == S_DC)  cnt_q <= word[CNT_W-1:0];
            if (st == S_UDW) cnt_q <= cnt_q - CNT_W'(1);
            if (st == S_CS && sel_q && (word[PAY_W-1:0] != sum_q)) csum_err <= 1'b1;
            else if (err_clr)                                      csum_err <= 1'b0;
        end
    end

endmodule

// File: rtl/anc_delay_line.sv
module anc_delay_line #(
    parameter int WORD_W   = 10,
    parameter int LAT      = 4,
    parameter int FLAG_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              kill_in,
    input  logic              retro,
    input  logic              ph_in,
    output logic [WORD_W-1:0] word_out,
    output logic              kill_out,
    output logic              ph_out
);
    logic [WORD_W-1:0] data_q [LAT];
    logic [LAT-1:0]    kill_q;
    logic [LAT-1:0]    ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q[0] <= '0;
            kill_q[0] <= 1'b0;
            ph_q[0]   <= 1'b0;
        end else begin
            data_q[0] <= word_in;
            kill_q[0] <= kill_in;
            ph_q[0]   <= ph_in;
        end
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        localparam bit TAP = (i <= FLAG_LEN);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                kill_q[i] <= 1'b0;
                ph_q[i]   <= 1'b0;
            end else begin
                data_q[i] <= data_q[i-1];
                kill_q[i] <= kill_q[i-1] | (TAP & retro);
                ph_q[i]   <= ph_q[i-1];
            end
        end
    end

    assign word_out = data_q[LAT-1];
    assign kill_out = kill_q[LAT-1];
    assign ph_out   = ph_q[LAT-1];

endmodule

// File: rtl/anc_pkt_extractor.sv
module anc_pkt_extractor #(
    parameter int         WORD_W  = 10,
    parameter int         ID_W    = 8,
    parameter int         LAT     = 4,
    parameter logic [9:0] BLANK_C = 10'h200,
    parameter logic [9:0] BLANK_Y = 10'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] vid_in,
    input  logic              remove_en,
    input  logic [ID_W-1:0]   id_audio,
    input  logic [ID_W-1:0]   id_ext_audio,
    input  logic [ID_W-1:0]   id_arbitrary,
    input  logic              err_clr,
    output logic [WORD_W-1:0] vid_out,
    output logic [WORD_W-2:0] pkt_data,
    output logic              pkt_valid,
    output logic              csum_err
);
    localparam int FLAG_LEN = 3;

    logic              kill_cur, retro, ph_q;
    logic [WORD_W-1:0] dly_word;
    logic              dly_kill, dly_ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    anc_parse_fsm #(.WORD_W(WORD_W), .ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .word(vid_in), .remove_en(remove_en),
        .id_a(id_audio), .id_b(id_ext_audio), .id_c(id_arbitrary),
        .err_clr(err_clr), .pkt_data(pkt_data), .pkt_valid(pkt_valid),
        .csum_err(csum_err), .kill_cur(kill_cur), .retro(retro)
    );

    anc_delay_line #(.WORD_W(WORD_W), .LAT(LAT), .FLAG_LEN(FLAG_LEN)) u_dly (
        .clk(clk), .rst_n(rst_n), .word_in(vid_in), .kill_in(kill_cur),
        .retro(retro), .ph_in(ph_q), .word_out(dly_word),
        .kill_out(dly_kill), .ph_out(dly_ph)
    );

    assign vid_out = dly_kill ? (dly_ph ? WORD_W'(BLANK_Y) : WORD_W'(BLANK_C)) : dly_word;

endmodule

// File: rtl/anc_pkt_extractor_chk.sv
module anc_pkt_extractor_chk
    import anc_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LAT    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_clr,
    input logic              csum_err,
    input logic              pkt_valid,
    input logic              remove_en,
    input parse_st_t         st,
    input logic              retro,
    input logic [WORD_W-1:0] d0,
    input logic [WORD_W-1:0] d1,
    input logic [WORD_W-1:0] d2,
    input logic              kill_last
);
    localparam int QUIET = LAT + 270;
    int quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          quiet_cnt <= QUIET;
        else if (remove_en && st == S_DID)   quiet_cnt <= 0;
        else if (quiet_cnt < QUIET)          quiet_cnt <= quiet_cnt + 1;
    end

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err && !err_clr |=> csum_err); // R11
    AST_EXPORT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(st) inside {S_SDID, S_DC, S_UDW}); // R4
    AST_RETRO_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        retro |-> (d0 == 10'h3FF) && (d1 == 10'h3FF) && (d2 == 10'h000)); // R2
    AST_DID_AFTER_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_DID |=> $past(st) == S_DID && st == S_SDID); // R2
    AST_KEEP_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt >= QUIET |-> !kill_last); // R8

endmodule

bind anc_pkt_extractor anc_pkt_extractor_chk #(.WORD_W(WORD_W), .LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .csum_err(csum_err),
    .pkt_valid(pkt_valid), .remove_en(remove_en), .st(u_fsm.st),
    .retro(retro), .d0(u_dly.data_q[0]), .d1(u_dly.data_q[1]),
    .d2(u_dly.data_q[2]), .kill_last(dly_kill)
);

// File: tb/anc_pkt_extractor_bench.sv
module anc_pkt_extractor_bench;
    localparam int LAT = 4;
    localparam int MAXW = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vid_in = 10'h080;
    logic       remove_en = 1'b0;
    logic [7:0] id_audio = 8'hE7, id_ext_audio = 8'hE3, id_arbitrary = 8'h5A;
    logic       err_clr = 1'b0;
    logic [9:0] vid_out;
    logic [8:0] pkt_data;
    logic       pkt_valid, csum_err;

    always #5 clk = ~clk;

    anc_pkt_extractor #(.LAT(LAT)) u_anc_pkt_extractor (
        .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .remove_en(remove_en),
        .id_audio(id_audio), .id_ext_audio(id_ext_audio), .id_arbitrary(id_arbitrary),
        .err_clr(err_clr), .vid_out(vid_out), .pkt_data(pkt_data),
        .pkt_valid(pkt_valid), .csum_err(csum_err)
    );

    logic [9:0] a_w   [MAXW];
    bit         a_kill[MAXW];
    bit         a_pv  [MAXW];
    bit         a_bad [MAXW];
    bit         a_clr [MAXW];
    int n_push = 0, n_run = 0, checks = 0, fails = 0;
    bit err_m = 1'b0;

    function automatic logic [9:0] mkw(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] w, input bit k, input bit pv, input bit bad, input bit clr);
        a_w[n_push] = w; a_kill[n_push] = k; a_pv[n_push] = pv;
        a_bad[n_push] = bad; a_clr[n_push] = clr;
        n_push++;
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) push(10'h080, 0, 0, 0, 0);
    endtask

    task automatic add_pkt(input logic [7:0] did, input logic [7:0] sdid, input int dc,
                           input int seed, input bit sel, input bit corrupt, input bit cs_clr);
        logic [8:0] s;
        logic [9:0] w;
        bit k;
        k = sel && remove_en;
        push(10'h000, k, 0, 0, 0);
        push(10'h3FF, k, 0, 0, 0);
        push(10'h3FF, k, 0, 0, 0);
        w = mkw(did);  s = w[8:0];        push(w, k, 0, 0, 0);
        w = mkw(sdid); s = s + w[8:0];    push(w, k, sel, 0, 0);
        w = mkw(8'(dc)); s = s + w[8:0];  push(w, k, sel, 0, 0);
        for (int u = 0; u < dc; u++) begin
            w = mkw(8'((seed + u * 7) & 8'hFF));
            s = s + w[8:0];
            push(w, k, sel, 0, 0);
        end
        w = {~s[8], s};
        if (corrupt) w[0] = ~w[0];
        push(w, k, 0, sel && corrupt, cs_clr);
    endtask

    // drive every pending word; compare outputs at each negedge first
    task automatic run(input string tag);
        fill(LAT + 2);
        while (n_run < n_push) begin
            int j;
            @(negedge clk);
            j = n_run;
            if (j < LAT) check(tag, "vid_out", vid_out, 0);
            else check(tag, "vid_out", vid_out,
                       a_kill[j-LAT] ? (((j - LAT) % 2) ? 10'h040 : 10'h200) : a_w[j-LAT]);
            check(tag, "pkt_valid", pkt_valid, a_pv[j-1]);
            if (a_pv[j-1]) check(tag, "pkt_data", pkt_data, a_w[j-1][8:0]);
            check(tag, "csum_err", csum_err, err_m);
            vid_in  = a_w[j];
            err_clr = a_clr[j];
            if (a_bad[j]) err_m = 1'b1;
            else if (a_clr[j]) err_m = 1'b0;
            n_run++;
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R1", "vid_out", vid_out, 0);
            check("R1", "pkt_valid", pkt_valid, 0);
            check("R1", "csum_err", csum_err, 0);
        end
        push(10'h080, 0, 0, 0, 0);
        rst_n  = 1'b1;
        vid_in = a_w[0];
        n_run  = 1;
        run("R1");
    endtask

    task automatic test_remove_audio();   // R3 R6 R7 R9
        remove_en = 1'b1;
        fill(1);
        add_pkt(8'hE7, 8'h02, 4, 8'h11, 1, 0, 0);
        fill(2);
        add_pkt(8'hE7, 8'h03, 3, 8'h40, 1, 0, 0);
        run("R6");
    endtask

    task automatic test_keep_ext();       // R8 R4
        remove_en = 1'b0;
        add_pkt(8'hE3, 8'h01, 5, 8'h21, 1, 0, 0);
        run("R8");
    endtask

    task automatic test_no_match();       // R3 R8
        remove_en = 1'b1;
        add_pkt(8'h77, 8'h01, 3, 8'h33, 0, 0, 0);
        fill(1);
        add_pkt(8'h5A, 8'h09, 2, 8'h08, 1, 0, 0);
        run("R3");
    endtask

    task automatic test_zero_count();     // R5
        remove_en = 1'b1;
        add_pkt(8'h5A, 8'h04, 0, 0, 1, 0, 0);
        add_pkt(8'hE3, 8'h05, 1, 8'h60, 1, 0, 0);
        run("R5");
    endtask

    task automatic test_marker();         // R2
        remove_en = 1'b1;
        push(10'h000, 0, 0, 0, 0);
        push(10'h3FF, 0, 0, 0, 0);
        push(mkw(8'hE7), 0, 0, 0, 0);
        push(mkw(8'h01), 0, 0, 0, 0);
        fill(3);
        push(10'h000, 0, 0, 0, 0);
        add_pkt(8'hE7, 8'h06, 2, 8'h50, 1, 0, 0);
        run("R2");
    endtask

    task automatic test_checksum();       // R10 R11
        remove_en = 1'b0;
        add_pkt(8'hE7, 8'h01, 3, 8'h15, 1, 1, 0);
        fill(3);
        push(10'h080, 0, 0, 0, 1);
        fill(3);
        add_pkt(8'h77, 8'h01, 2, 8'h15, 0, 1, 0);  // unselected: no flag
        add_pkt(8'hE3, 8'h02, 2, 8'h44, 1, 1, 1);  // set wins over clear
        fill(2);
        push(10'h080, 0, 0, 0, 1);
        run("R10");
        check("R11", "csum_err final", csum_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_remove_audio();
        test_keep_ext();
        test_no_match();
        test_zero_count();
        test_marker();
        test_checksum();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule